// File: doc/BRIEF.md
# Opcode-Addressed Serial Register Port

This block is the host-facing serial slave of a bus controller that has two receive channels and one transmit channel. A host drives a four-wire SPI link (mode 0: data sampled on the rising clock edge, changed on the falling edge). Each transfer opens with an 8-bit opcode. Its top bit gives the direction and its next five bits give a register address. A data field follows, and its length is set by the addressed register.

The port owns a 4-bit clock-division register. It also assembles three status bytes from flag inputs that the FIFO logic drives. Longer fields carry 32-bit data words and 256-bit label-enable maps. The port does not store these. It streams them byte by byte to the rest of the device, using a write strobe for host writes and a read request for host reads.

The SPI pins are resynchronized into the system clock. The serial clock must therefore run at no more than one quarter of the system clock.

Top module: `spi_regport`

## Requirements
- R1: While chip select is low, the first 8 rising SCK edges shift an opcode in from MOSI, MSB first. Opcode bit 7 chooses read (1) or write (0). Bits 6..2 form the register address. Bits 1..0 are ignored, so 0xD7 reads the same register as 0xD4.
- R2: For a write, the data MSB is the bit sampled on the rising edge right after the 8th opcode bit. Opcode 0x38 writes the clock divider from data bits 4..1, and the other bits have no effect. The divider resets to 0.
- R3: For a read, the data MSB appears on MISO at the falling edge after the 8th opcode rising edge. The remaining bits follow MSB first on later falling edges. Opcode 0xD4 returns {3'b000, divider, 1'b0}.
- R4: Opcode 0x80 returns the transmit status byte {5'b0, full, half, empty}, taken from tx_fifo_flags[2:0] in that order.
- R5: Opcodes 0x90 and 0xB0 return the receive status byte of channel 1 and channel 2, laid out as {2'b0, hit3, hit2, hit1, full, half, empty}. The hit bits come from rxN_label_hits[2:0] and the FIFO bits come from rxN_fifo_flags[2:0].
- R6: The data field length depends on the opcode:
  - 32 bits for opcode 0x0C (word write) and for opcodes 0xA0 and 0xC0 (word reads of channel 1 and channel 2).
  - 256 bits for opcodes 0x14 and 0x24 (label-map writes) and for opcodes 0x98 and 0xA8 (label-map reads).
  - 8 bits for every other opcode.

  SCK edges beyond the field are ignored, and MISO reads 0 there.
- R7: Each completed byte of a 32-bit or 256-bit write field pulses ext_wr_valid for one clock. The pulse carries ext_addr (opcode bits 6..2), ext_byte_idx (0 for the first byte after the opcode) and ext_wr_data.
- R8: Each byte of a 32-bit or 256-bit read field pulses ext_rd_req for one clock, with ext_addr and ext_byte_idx set. ext_rd_data is taken in that same clock and shifted out MSB first.
- R9: Raising chip select ends the transfer at once. It discards any incomplete data byte, so a cut 0x38 write leaves the divider unchanged and a cut long write issues only its completed bytes. The next transfer starts with a fresh opcode.
- R10: Reading any other address returns 0x00. Writing any other address changes nothing and issues no strobe.
- R11: After reset, and while chip select is high, MISO is 0 and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| tx_fifo_flags | input | 3 | Transmit FIFO {full, half, empty} |
| rx1_fifo_flags | input | 3 | Channel 1 receive FIFO {full, half, empty} |
| rx1_label_hits | input | 3 | Channel 1 priority-label hits {3, 2, 1} |
| rx2_fifo_flags | input | 3 | Channel 2 receive FIFO {full, half, empty} |
| rx2_label_hits | input | 3 | Channel 2 priority-label hits {3, 2, 1} |
| clk_div | output | 4 | Clock-division value |
| ext_wr_valid | output | 1 | One-clock strobe for a completed long-field write byte |
| ext_rd_req | output | 1 | One-clock request for a long-field read byte |
| ext_addr | output | 5 | Register address of the current transfer |
| ext_byte_idx | output | 5 | Byte index within the long field |
| ext_wr_data | output | 8 | Write byte that goes with ext_wr_valid |
| ext_rd_data | input | 8 | Read byte, valid while ext_rd_req is high |

## Verification
The opcode decoder is driven with:
- every mapped opcode;
- copies of those opcodes with the two ignored bits set;
- read and write opcodes aimed at each other's addresses;
- a fully unmapped address.

Together these separate a correct address slice from one that is off by one bit. The status inputs take several non-symmetric patterns, so any swapped or shifted bit shows up on MISO.

Field lengths are probed in three ways. Transfers are overclocked past 8, 32 and 256 bits. Transfers are cut short inside a data byte. A full 256-bit label stream checks that the byte index and data ordering hold across every byte boundary.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int OP_W       = 8;
    localparam int ADDR_W     = 5;
    localparam int BYTE_W     = 8;
    localparam int WORD_BITS  = 32;
    localparam int LBL_BITS   = 256;
    localparam int WORD_BYTES = WORD_BITS / BYTE_W;
    localparam int LBL_BYTES  = LBL_BITS / BYTE_W;
    localparam int IDX_W      = $clog2(LBL_BYTES);
    localparam int DIV_W      = 4;
    localparam int FLAG_W     = 3;

    // register addresses (opcode bits 6..2)
    localparam logic [ADDR_W-1:0] A_TX_STAT  = 5'd0;   // read 0x80
    localparam logic [ADDR_W-1:0] A_RX1_STAT = 5'd4;   // read 0x90
    localparam logic [ADDR_W-1:0] A_RX2_STAT = 5'd12;  // read 0xB0
    localparam logic [ADDR_W-1:0] A_DIV_WR   = 5'd14;  // write 0x38
    localparam logic [ADDR_W-1:0] A_DIV_RD   = 5'd21;  // read 0xD4
    localparam logic [ADDR_W-1:0] A_TX_WORD  = 5'd3;   // write 0x0C
    localparam logic [ADDR_W-1:0] A_RX1_WORD = 5'd8;   // read 0xA0
    localparam logic [ADDR_W-1:0] A_RX2_WORD = 5'd16;  // read 0xC0
    localparam logic [ADDR_W-1:0] A_LBL1_WR  = 5'd5;   // write 0x14
    localparam logic [ADDR_W-1:0] A_LBL2_WR  = 5'd9;   // write 0x24
    localparam logic [ADDR_W-1:0] A_LBL1_RD  = 5'd6;   // read 0x98
    localparam logic [ADDR_W-1:0] A_LBL2_RD  = 5'd10;  // read 0xA8

    typedef enum logic [1:0] {
        PH_OPC  = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    function automatic logic is_word(input logic rd, input logic [ADDR_W-1:0] a);
        if (rd) return (a == A_RX1_WORD) || (a == A_RX2_WORD);
        return a == A_TX_WORD;
    endfunction

    function automatic logic is_lbl(input logic rd, input logic [ADDR_W-1:0] a);
        if (rd) return (a == A_LBL1_RD) || (a == A_LBL2_RD);
        return (a == A_LBL1_WR) || (a == A_LBL2_WR);
    endfunction

    function automatic logic is_ext(input logic rd, input logic [ADDR_W-1:0] a);
        return is_word(rd, a) || is_lbl(rd, a);
    endfunction

    // index of the final byte of the data field
    function automatic logic [IDX_W-1:0] last_idx(input logic rd, input logic [ADDR_W-1:0] a);
        if (is_word(rd, a)) return IDX_W'(WORD_BYTES - 1);
        if (is_lbl(rd, a))  return IDX_W'(LBL_BYTES - 1);
        return '0;
    endfunction

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              csn_s,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              dir,
    output logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              rd_load,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              miso
);

    typedef struct packed {
        phase_e              phase;
        logic                sck_prev;
        logic [2:0]          bit_cnt;
        logic [IDX_W-1:0]    byte_idx;
        logic [IDX_W-1:0]    wr_idx;
        logic [ADDR_W:0]     op;       // {dir, addr}; opcode bits 1..0 never stored
        logic [BYTE_W-1:0]   shin;
        logic [BYTE_W-1:0]   shout;
        logic                miso;
        logic                rd_load;
        logic                wr_valid;
    } frame_t;

    frame_t d, q;
    logic rise, fall;
    logic [IDX_W-1:0] last;

    always_comb begin
        d          = q;
        d.sck_prev = sck_s;
        d.rd_load  = 1'b0;
        d.wr_valid = 1'b0;
        rise       = sck_s & ~q.sck_prev;
        fall       = ~sck_s & q.sck_prev;
        last       = last_idx(q.op[ADDR_W], q.op[ADDR_W-1:0]);

        if (csn_s) begin
            d          = '0;
            d.sck_prev = sck_s;
        end else begin
            if (q.rd_load) d.shout = rd_byte;
            unique case (q.phase)
                PH_OPC: begin
                    if (rise) begin
                        if (q.bit_cnt < 3'd6) d.op = {q.op[ADDR_W-1:0], mosi_s};
                        d.bit_cnt = q.bit_cnt + 3'd1;
                        if (q.bit_cnt == 3'd7) begin
                            d.phase    = PH_DATA;
                            d.byte_idx = '0;
                            d.rd_load  = q.op[ADDR_W];
                        end
                    end
                end
                PH_DATA: begin
                    if (rise) begin
                        d.shin    = {q.shin[BYTE_W-2:0], mosi_s};
                        d.bit_cnt = q.bit_cnt + 3'd1;
                        if (q.bit_cnt == 3'd7) begin
                            d.wr_valid = ~q.op[ADDR_W];
                            d.wr_idx   = q.byte_idx;
                            if (q.byte_idx == last) begin
                                d.phase = PH_DONE;
                            end else begin
                                d.byte_idx = q.byte_idx + 1'b1;
                                d.rd_load  = q.op[ADDR_W];
                            end
                        end
                    end
                    if (fall && q.op[ADDR_W]) begin
                        d.miso  = q.shout[BYTE_W-1];
                        d.shout = {q.shout[BYTE_W-2:0], 1'b0};
                    end
                end
                PH_DONE: begin
                    if (fall) d.miso = 1'b0;
                end
                default: d.phase = PH_OPC;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dir      = q.op[ADDR_W];
    assign addr     = q.op[ADDR_W-1:0];
    assign idx      = q.wr_valid ? q.wr_idx : q.byte_idx;
    assign rd_load  = q.rd_load;
    assign wr_valid = q.wr_valid;
    assign wr_byte  = q.shin;
    assign miso     = q.miso;

    // deselect ends everything on the next clock
    assert_deselect_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> (!q.wr_valid && !q.rd_load));

    assert_miso_low_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !q.miso);

    assert_idx_within_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_DATA) |-> (q.byte_idx <= last_idx(q.op[ADDR_W], q.op[ADDR_W-1:0])));

    assert_done_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_DONE) |=> (!q.wr_valid && !q.rd_load));

    assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.wr_valid && q.rd_load));

endmodule

// File: rtl/spi_regport_regs.sv
module spi_regport_regs
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_valid,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic [FLAG_W-1:0] tx_flags,
    input  logic [FLAG_W-1:0] rx1_flags,
    input  logic [FLAG_W-1:0] rx1_hits,
    input  logic [FLAG_W-1:0] rx2_flags,
    input  logic [FLAG_W-1:0] rx2_hits,
    input  logic [BYTE_W-1:0] ext_rd_data,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [DIV_W-1:0]  clk_div,
    output logic              ext_wr_valid
);

    logic [DIV_W-1:0] div_d, div_q;
    logic             div_we;

    always_comb begin
        div_we = wr_valid && !dir && (addr == A_DIV_WR);
        div_d  = div_we ? div_wdata : div_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    always_comb begin
        rd_byte = '0;
        if (dir) begin
            if (is_ext(1'b1, addr)) begin
                rd_byte = ext_rd_data;
            end else begin
                unique case (addr)
                    A_TX_STAT:  rd_byte = {5'b0, tx_flags};
                    A_RX1_STAT: rd_byte = {2'b0, rx1_hits, rx1_flags};
                    A_RX2_STAT: rd_byte = {2'b0, rx2_hits, rx2_flags};
                    A_DIV_RD:   rd_byte = {3'b0, div_q, 1'b0};
                    default:    rd_byte = '0;
                endcase
            end
        end
    end

    assign clk_div      = div_q;
    assign ext_wr_valid = wr_valid && !dir && is_ext(1'b0, addr);

    assert_div_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !div_we |=> $stable(div_q));

    assert_div_ext_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(div_we && ext_wr_valid));

endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [FLAG_W-1:0] tx_fifo_flags,
    input  logic [FLAG_W-1:0] rx1_fifo_flags,
    input  logic [FLAG_W-1:0] rx1_label_hits,
    input  logic [FLAG_W-1:0] rx2_fifo_flags,
    input  logic [FLAG_W-1:0] rx2_label_hits,
    output logic [DIV_W-1:0]  clk_div,
    output logic              ext_wr_valid,
    output logic              ext_rd_req,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [IDX_W-1:0]  ext_byte_idx,
    output logic [BYTE_W-1:0] ext_wr_data,
    input  logic [BYTE_W-1:0] ext_rd_data
);

    logic [2:0]        pins_s;
    logic              dir, rd_load, wr_valid;
    logic [ADDR_W-1:0] addr;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] rd_byte, wr_byte;

    spi_regport_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_sck, spi_csn, spi_mosi}),
        .dout (pins_s)
    );

    spi_regport_frame frame_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (pins_s[2]),
        .csn_s   (pins_s[1]),
        .mosi_s  (pins_s[0]),
        .rd_byte (rd_byte),
        .dir     (dir),
        .addr    (addr),
        .idx     (idx),
        .rd_load (rd_load),
        .wr_valid(wr_valid),
        .wr_byte (wr_byte),
        .miso    (spi_miso)
    );

    spi_regport_regs regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dir         (dir),
        .addr        (addr),
        .wr_valid    (wr_valid),
        .div_wdata   (wr_byte[DIV_W:1]),
        .tx_flags    (tx_fifo_flags),
        .rx1_flags   (rx1_fifo_flags),
        .rx1_hits    (rx1_label_hits),
        .rx2_flags   (rx2_fifo_flags),
        .rx2_hits    (rx2_label_hits),
        .ext_rd_data (ext_rd_data),
        .rd_byte     (rd_byte),
        .clk_div     (clk_div),
        .ext_wr_valid(ext_wr_valid)
    );

    assign ext_rd_req   = rd_load && is_ext(1'b1, addr);
    assign ext_addr     = addr;
    assign ext_byte_idx = idx;
    assign ext_wr_data  = wr_byte;

endmodule

// File: tb/spi_regport_tb.sv
`timescale 1ns/1ps
module spi_regport_tb_top;

    localparam int HALF = 6;       // clocks per SCK half period
    localparam int WD   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic miso;
    logic [2:0] tx_f = 3'b001, r1_f = 3'b000, r1_h = 3'b000, r2_f = 3'b000, r2_h = 3'b000;
    logic [3:0] clk_div;
    logic ext_wr_valid, ext_rd_req;
    logic [4:0] ext_addr, ext_byte_idx;
    logic [7:0] ext_wr_data, ext_rd_data;

    int n_chk = 0, n_fail = 0;
    int rd_req_cnt = 0, cs_hi_cnt = 0;
    bit finished = 0;
    logic [17:0] wq[$];

    always #10 clk = ~clk;

    spi_regport dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(miso), .tx_fifo_flags(tx_f), .rx1_fifo_flags(r1_f),
        .rx1_label_hits(r1_h), .rx2_fifo_flags(r2_f), .rx2_label_hits(r2_h),
        .clk_div(clk_div), .ext_wr_valid(ext_wr_valid), .ext_rd_req(ext_rd_req),
        .ext_addr(ext_addr), .ext_byte_idx(ext_byte_idx), .ext_wr_data(ext_wr_data),
        .ext_rd_data(ext_rd_data)
    );

    function automatic logic [7:0] rdf(input logic [4:0] a, input logic [4:0] i);
        return 8'((int'(a) * 37 + int'(i) * 11 + 5) & 255);
    endfunction

    always_comb ext_rd_data = rdf(ext_addr, ext_byte_idx);

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock reference monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (ext_wr_valid) wq.push_back({ext_addr, ext_byte_idx, ext_wr_data});
            if (ext_rd_req) rd_req_cnt++;
            cs_hi_cnt = csn ? cs_hi_cnt + 1 : 0;
            if (cs_hi_cnt >= 4) begin
                chk(miso == 1'b0, "R11 miso idle", 256'(miso), 256'(0));
                chk(!ext_wr_valid && !ext_rd_req, "R11 no strobe", 256'({ext_wr_valid, ext_rd_req}), 256'(0));
            end
            if (ext_wr_valid && ext_rd_req) chk(1'b0, "R8 strobe overlap", 256'(3), 256'(0));
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    // opcode then nbits of data (MSB of wd[nbits-1] first); rd collects MISO per data bit
    task automatic spi_xfer(input logic [7:0] op, input int nbits, input logic [255:0] wd,
                            output logic [255:0] rd);
        rd = '0;
        csn = 1'b0;
        hold(HALF);
        for (int b = 0; b < 8 + nbits; b++) begin
            mosi = (b < 8) ? op[7 - b] : wd[nbits - 1 - (b - 8)];
            hold(HALF);
            if (b >= 8) rd = {rd[254:0], miso};
            sck = 1'b1;
            hold(HALF);
            sck = 1'b0;
        end
        hold(HALF);
        csn = 1'b1;
        hold(3 * HALF);
    endtask

    task automatic check_writes(input logic [4:0] a, input int nbytes, input logic [255:0] data,
                                input string req);
        chk(wq.size() == nbytes, req, 256'(wq.size()), 256'(nbytes));
        for (int k = 0; k < nbytes && k < wq.size(); k++) begin
            logic [17:0] e;
            e = {a, 5'(k), data[(nbytes - 1 - k) * 8 +: 8]};
            chk(wq[k] == e, req, 256'(wq[k]), 256'(e));
        end
    endtask

    initial begin
        logic [255:0] r, lbl, exp;
        hold(5);
        rst_n = 1'b1;
        hold(5);
        // R11 / R2 reset state
        chk(miso == 1'b0, "R11 reset miso", 256'(miso), 256'(0));
        chk(clk_div == 4'd0, "R2 reset divider", 256'(clk_div), 256'(0));

        // R4 transmit status, two patterns
        tx_f = 3'b001;
        spi_xfer(8'h80, 8, '0, r);
        chk(r[7:0] == 8'h01, "R4 tx status empty", r, 256'h01);
        tx_f = 3'b110;
        spi_xfer(8'h80, 8, '0, r);
        chk(r[7:0] == 8'h06, "R4 tx status full+half", r, 256'h06);

        // R5 receive status per channel
        r1_f = 3'b010; r1_h = 3'b101; r2_f = 3'b001; r2_h = 3'b010;
        spi_xfer(8'h90, 8, '0, r);
        chk(r[7:0] == 8'h2A, "R5 rx1 status", r, 256'h2A);
        spi_xfer(8'hB0, 8, '0, r);
        chk(r[7:0] == 8'h11, "R5 rx2 status", r, 256'h11);

        // R2 / R3 divider write and readback
        spi_xfer(8'h38, 8, 256'hB6, r);
        chk(clk_div == 4'hB, "R2 divider write", 256'(clk_div), 256'hB);
        spi_xfer(8'hD4, 8, '0, r);
        chk(r[7:0] == 8'h16, "R3 divider readback", r, 256'h16);
        // R1 ignored opcode bits
        spi_xfer(8'hD7, 8, '0, r);
        chk(r[7:0] == 8'h16, "R1 ignored low bits read", r, 256'h16);
        spi_xfer(8'h3B, 8, 256'h08, r);
        chk(clk_div == 4'h4, "R1 ignored low bits write", 256'(clk_div), 256'h4);

        // R10 unmapped access
        wq.delete();
        spi_xfer(8'hFC, 8, '0, r);
        chk(r[7:0] == 8'h00, "R10 unmapped read", r, 256'h0);
        spi_xfer(8'hB8, 8, '0, r);
        chk(r[7:0] == 8'h00, "R10 read of write-only address", r, 256'h0);
        spi_xfer(8'h7C, 8, 256'hFF, r);
        chk(clk_div == 4'h4, "R10 unmapped write divider", 256'(clk_div), 256'h4);
        chk(wq.size() == 0, "R10 unmapped write strobes", 256'(wq.size()), 256'(0));

        // R6 overclocked 8-bit fields
        spi_xfer(8'h80, 16, '0, r);
        chk(r[15:0] == 16'h0600, "R6 read past field", r, 256'h0600);
        spi_xfer(8'h38, 16, 256'h06FF, r);
        chk(clk_div == 4'h3, "R6 write past field", 256'(clk_div), 256'h3);

        // R9 cut write, then fresh transaction
        spi_xfer(8'h38, 5, 256'h1F, r);
        chk(clk_div == 4'h3, "R9 partial write discarded", 256'(clk_div), 256'h3);
        spi_xfer(8'hD4, 8, '0, r);
        chk(r[7:0] == 8'h06, "R9 fresh opcode after cut", r, 256'h06);

        // R7 word write
        wq.delete();
        spi_xfer(8'h0C, 32, 256'hDEADBEEF, r);
        check_writes(5'd3, 4, 256'hDEADBEEF, "R7 word write");
        // R6 word write overclocked by one byte
        wq.delete();
        spi_xfer(8'h0C, 40, 256'hCAFEF00D77, r);
        check_writes(5'd3, 4, 256'hCAFEF00D, "R6 word field length");
        // R9 cut long write
        wq.delete();
        spi_xfer(8'h0C, 12, 256'hABC, r);
        check_writes(5'd3, 1, 256'hAB, "R9 cut word write");

        // R7 / R6 label-map write, 256 bits
        lbl = '0;
        for (int k = 0; k < 32; k++) lbl = {lbl[247:0], 8'(k * 7 + 1)};
        wq.delete();
        spi_xfer(8'h24, 256, lbl, r);
        check_writes(5'd9, 32, lbl, "R7 label write");

        // R8 word read
        rd_req_cnt = 0;
        spi_xfer(8'hA0, 32, '0, r);
        exp = '0;
        for (int k = 0; k < 4; k++) exp = {exp[247:0], rdf(5'd8, 5'(k))};
        chk(r[31:0] == exp[31:0], "R8 word read", r, exp);
        chk(rd_req_cnt == 4, "R8 word read requests", 256'(rd_req_cnt), 256'(4));

        // R8 / R6 label-map read, 256 bits
        rd_req_cnt = 0;
        spi_xfer(8'h98, 256, '0, r);
        exp = '0;
        for (int k = 0; k < 32; k++) exp = {exp[247:0], rdf(5'd6, 5'(k))};
        chk(r == exp, "R8 label read", r, exp);
        chk(rd_req_cnt == 32, "R6 label read length", 256'(rd_req_cnt), 256'(32));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule